// File: doc/BRIEF.md
# Two-Page Serial EEPROM Slave with Page-Write Staging

This block is the bus-facing half of a small nonvolatile byte store that answers as a slave on a two-wire serial bus. A fast system clock oversamples the clock and data lines, recognises start and stop conditions, and decodes a device byte followed by a word pointer. Data bytes from the master are acknowledged and held in an eight-entry staging buffer. Nothing reaches the storage array until the master closes the transfer with a stop condition. At that point the staged bytes go into a 512-byte register array, and a timed busy window starts.

The array has two 256-byte halves. Bit 1 of the device byte chooses the half. Two pin inputs must match the two device-select bits above it. A protect input locks the upper half: addressing still works there, but incoming data is refused. The master can read back through the same bus. Reads start at the current pointer and run sequentially until the master answers a byte with no acknowledge.

Top module: `eeprom_i2c_wr`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), the device is not busy, and every array byte reads as 8'hFF.
- R2: The device byte is acknowledged only when bits [7:4] are 4'b1010 and bits [3:2] equal `dev_sel`. Bit 1 selects the array half and forms array address bit 8. Bit 0 set to 1 means a read.
- R3: In a write, the word pointer byte is acknowledged, and then so is each data byte. Each byte lands at {half, pointer}. After every accepted byte only the pointer's low three bits advance, wrapping inside an eight-byte group, while the upper five bits stay fixed. The slave changes SDA only while SCL is low.
- R4: A ninth data byte before stop is not acknowledged. The whole transfer is then dropped and the array is unchanged.
- R5: A stop with n ≥ 1 staged bytes starts a busy window of ERASE_CYC + n·BYTE_CYC system cycles. The array is updated in the last cycle of that window.
- R6: While busy, the device byte gets no acknowledge and no bus activity can stage data.
- R7: With `wp` high and the upper half selected, the device and pointer bytes are acknowledged, every data byte is refused, and nothing is written. The lower half stays writable.
- R8: With `wp` low, the upper half is writable.
- R9: A repeated start drops any staged bytes without committing them and keeps the word pointer.
- R10: A read-direction device byte is acknowledged when not busy. Bytes are then sent MSB first from the pointer, which advances by one with an 8-bit wrap inside the half. After the master's no-acknowledge, SDA is released.
- R11: A stop with no staged data byte starts no busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| dev_sel | input | 2 | Device-select strap compared with device byte bits [3:2] |
| wp | input | 1 | Protect input for the upper array half |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain drive) |

## Verification
The checker watches four properties on every cycle: SDA is silent during the busy window, SDA edges fall only while SCL is low, nothing is staged while busy, and a commit is followed at once by a busy window that ends in the cycle after the array write. The bench's scenarios are the only place where the byte-level outcomes show: acknowledge patterns for wrong device bytes, the low-three-bit wrap, overrun discard, protect refusal, and repeated-start discard. Each of these is confirmed by reading the array back over the bus. Busy duration is measured by polling the device byte inside and after the expected window.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int          BYTE_W     = 8;
    localparam int          PAGE_BYTES = 8;
    localparam int          IDX_W      = $clog2(PAGE_BYTES);
    localparam int          ARR_AW     = 9;
    localparam int          ARR_BYTES  = 1 << ARR_AW;
    localparam int          BASE_W     = ARR_AW - IDX_W;
    localparam logic [3:0]  DEV_TYPE   = 4'b1010;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_WDATA,
        ST_RDATA
    } link_state_e;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        byte_t             data;
    } stage_req_t;

    function automatic logic [IDX_W:0] count_valid(input logic [PAGE_BYTES-1:0] v);
        logic [IDX_W:0] n;
        n = '0;
        for (int k = 0; k < PAGE_BYTES; k++) begin
            n = n + {{IDX_W{1'b0}}, v[k]};
        end
        return n;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise,
    output logic scl_fall
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            scl_q     <= scl_chain[STAGES-1];
            sda_q     <= sda_chain[STAGES-1];
        end
    end

    assign scl_s    = scl_chain[STAGES-1];
    assign sda_s    = sda_chain[STAGES-1];
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import eeprom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic [1:0]        dev_sel,
    input  logic              wp,
    input  logic              busy,
    input  byte_t             rd_data,
    output logic              sda_oe,
    output logic [ARR_AW-1:0] rd_addr,
    output stage_req_t        stage,
    output logic              stage_clr,
    output logic              commit,
    output logic [BASE_W-1:0] commit_base
);

    link_state_e state;
    logic [3:0]  bitcnt;
    logic        in_ack;
    logic        ack_pend;
    logic        rnw;
    logic        half;
    logic        refuse;
    logic [6:0]  shreg;
    byte_t       word;
    byte_t       tx;
    logic [3:0]  nbytes;

    byte_t rx_byte;
    logic  dev_hit;
    logic  wr_block;
    logic  rx_state;

    assign rx_byte     = {shreg, sda_s};
    assign dev_hit     = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:2] == dev_sel) && !busy;
    assign wr_block    = refuse || (nbytes == 4'(PAGE_BYTES)) || (wp && half);
    assign rx_state    = (state == ST_DEV) || (state == ST_WORD) || (state == ST_WDATA);
    assign rd_addr     = {half, word};
    assign commit_base = {half, word[7:IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            in_ack    <= 1'b0;
            ack_pend  <= 1'b0;
            rnw       <= 1'b0;
            half      <= 1'b0;
            refuse    <= 1'b0;
            shreg     <= '0;
            word      <= '0;
            tx        <= '0;
            nbytes    <= '0;
            sda_oe    <= 1'b0;
            stage     <= '0;
            stage_clr <= 1'b0;
            commit    <= 1'b0;
        end else begin
            stage.we  <= 1'b0;
            stage_clr <= 1'b0;
            commit    <= 1'b0;
            if (start_p) begin
                state     <= ST_DEV;
                bitcnt    <= '0;
                in_ack    <= 1'b0;
                sda_oe    <= 1'b0;
                nbytes    <= '0;
                refuse    <= 1'b0;
                stage_clr <= 1'b1;
            end else if (stop_p) begin
                if (state == ST_WDATA && nbytes != 4'd0 && !refuse) begin
                    commit <= 1'b1;
                end
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && !in_ack && bitcnt != 4'd8) begin
                    shreg  <= rx_byte[6:0];
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt == 4'd7) begin
                        unique case (state)
                            ST_DEV: begin
                                ack_pend <= dev_hit;
                                half     <= rx_byte[1];
                                rnw      <= rx_byte[0];
                            end
                            ST_WORD: begin
                                ack_pend <= 1'b1;
                                word     <= rx_byte;
                            end
                            default: begin
                                if (wr_block) begin
                                    ack_pend <= 1'b0;
                                    refuse   <= 1'b1;
                                end else begin
                                    ack_pend    <= 1'b1;
                                    stage.we    <= 1'b1;
                                    stage.idx   <= word[IDX_W-1:0];
                                    stage.data  <= rx_byte;
                                    word        <= {word[7:IDX_W], word[IDX_W-1:0] + 1'b1};
                                    nbytes      <= nbytes + 4'd1;
                                end
                            end
                        endcase
                    end
                end else if (scl_fall && bitcnt == 4'd8 && !in_ack) begin
                    in_ack <= 1'b1;
                    sda_oe <= ack_pend;
                end else if (scl_fall && in_ack) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    sda_oe <= 1'b0;
                    unique case (state)
                        ST_DEV: begin
                            if (!ack_pend) begin
                                state <= ST_IDLE;
                            end else if (rnw) begin
                                state  <= ST_RDATA;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                word   <= word + 8'd1;
                            end else begin
                                state <= ST_WORD;
                            end
                        end
                        ST_WORD: state <= ST_WDATA;
                        default: state <= ST_WDATA;
                    endcase
                end
            end else if (state == ST_RDATA) begin
                if (scl_rise && bitcnt == 4'd8) begin
                    ack_pend <= ~sda_s;
                end else if (scl_fall) begin
                    if (bitcnt < 4'd7) begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        bitcnt <= 4'd8;
                    end else if (ack_pend) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        word   <= word + 8'd1;
                        bitcnt <= '0;
                    end else begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
    import eeprom_pkg::*;
#(
    parameter int ERASE_CYC = 400,
    parameter int BYTE_CYC  = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  stage_req_t        stage,
    input  logic              stage_clr,
    input  logic              commit,
    input  logic [BASE_W-1:0] commit_base,
    input  logic [ARR_AW-1:0] rd_addr,
    output byte_t             rd_data,
    output logic              busy,
    output logic              mem_we
);

    localparam int MAX_CYC = ERASE_CYC + PAGE_BYTES * BYTE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    byte_t                 arr  [ARR_BYTES];
    byte_t                 pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid;
    logic [BASE_W-1:0]     base;
    logic [CNT_W-1:0]      cnt;

    assign busy    = (cnt != '0);
    assign mem_we  = (cnt == CNT_W'(1));
    assign rd_data = arr[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARR_BYTES; a++) begin
                arr[a] <= 8'hFF;
            end
            for (int b = 0; b < PAGE_BYTES; b++) begin
                pbuf[b] <= '0;
            end
            valid <= '0;
            base  <= '0;
            cnt   <= '0;
        end else if (busy) begin
            cnt <= cnt - CNT_W'(1);
            if (mem_we) begin
                for (int j = 0; j < PAGE_BYTES; j++) begin
                    if (valid[j]) begin
                        arr[{base, IDX_W'(j)}] <= pbuf[j];
                    end
                end
                valid <= '0;
            end
        end else begin
            if (stage_clr) begin
                valid <= '0;
            end else if (stage.we) begin
                pbuf[stage.idx]  <= stage.data;
                valid[stage.idx] <= 1'b1;
            end
            if (commit) begin
                base <= commit_base;
                cnt  <= CNT_W'(ERASE_CYC) + CNT_W'(count_valid(valid)) * CNT_W'(BYTE_CYC);
            end
        end
    end

endmodule

// File: rtl/eeprom_i2c_wr.sv
module eeprom_i2c_wr
    import eeprom_pkg::*;
#(
    parameter int ERASE_CYC   = 400,
    parameter int BYTE_CYC    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel,
    input  logic       wp,
    output logic       sda_oe
);

    logic              scl_s;
    logic              sda_s;
    logic              start_p;
    logic              stop_p;
    logic              scl_rise;
    logic              scl_fall;
    logic              busy;
    logic              mem_we;
    byte_t             rd_data;
    logic [ARR_AW-1:0] rd_addr;
    stage_req_t        stage;
    logic              stage_we;
    logic              stage_clr;
    logic              commit;
    logic [BASE_W-1:0] commit_base;

    assign stage_we = stage.we;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_slave_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sda_s       (sda_s),
        .start_p     (start_p),
        .stop_p      (stop_p),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .dev_sel     (dev_sel),
        .wp          (wp),
        .busy        (busy),
        .rd_data     (rd_data),
        .sda_oe      (sda_oe),
        .rd_addr     (rd_addr),
        .stage       (stage),
        .stage_clr   (stage_clr),
        .commit      (commit),
        .commit_base (commit_base)
    );

    eeprom_store #(.ERASE_CYC(ERASE_CYC), .BYTE_CYC(BYTE_CYC)) u_store (
        .clk         (clk),
        .rst         (rst),
        .stage       (stage),
        .stage_clr   (stage_clr),
        .commit      (commit),
        .commit_base (commit_base),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .busy        (busy),
        .mem_we      (mem_we)
    );

endmodule

// File: rtl/eeprom_i2c_chk.sv
module eeprom_i2c_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic sda_oe,
    input logic scl_s,
    input logic commit,
    input logic mem_we,
    input logic stage_we
);

    AST_SILENT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);                                                   // R6

    AST_NO_STAGE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        stage_we |-> !busy);                                                 // R6

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);                                        // R3

    AST_COMMIT_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (commit && !busy) |=> busy);                                         // R5

    AST_WRITE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !busy);                                                   // R5

    AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);                                                    // R5

endmodule

bind eeprom_i2c_wr eeprom_i2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .sda_oe   (sda_oe),
    .scl_s    (scl_s),
    .commit   (commit),
    .mem_we   (mem_we),
    .stage_we (stage_we)
);

// File: tb/sim_eeprom_i2c_wr.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_wr;

    localparam int        Q     = 4;
    localparam int        ERASE = 400;
    localparam int        BYTEC = 100;
    localparam logic [1:0] DS   = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [512];

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    eeprom_i2c_wr #(.ERASE_CYC(ERASE), .BYTE_CYC(BYTEC)) u0 (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .dev_sel (DS),
        .wp      (wp),
        .sda_oe  (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic half, input logic rd);
        return {4'b1010, DS, half, rd};
    endfunction

    function automatic logic [7:0] nxt_wr(input logic [7:0] a);
        return {a[7:3], a[2:0] + 3'd1};
    endfunction

    task automatic i2c_start();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        bit got;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        end
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        got = (sda_bus == 1'b0);
        tick(Q); scl = 1'b0;
        check(got == exp_ack, tag, int'(got), int'(exp_ack));
    endtask

    task automatic rcv(input logic [7:0] exp_b, input bit mack, input string tag);
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
            got[i] = sda_bus;
            tick(Q); scl = 1'b0;
        end
        tick(Q); m_sda = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        tick(Q); m_sda = 1'b1;
        check(got == exp_b, tag, int'(got), int'(exp_b));
    endtask

    task automatic read_seq(input logic half, input logic [7:0] a, input int n, input string tag);
        logic [7:0] p;
        p = a;
        i2c_start();
        send(dev(half, 1'b0), 1'b1, tag);
        send(a, 1'b1, tag);
        i2c_start();
        send(dev(half, 1'b1), 1'b1, tag);
        for (int i = 0; i < n; i++) begin
            rcv(mem_m[{half, p}], (i != n - 1), tag);
            p = p + 8'd1;
        end
        tick(3*Q);
        check(sda_oe == 1'b0, "R10 release after NACK", int'(sda_oe), 0);
        i2c_stop();
    endtask

    task automatic write_seq(input logic half, input logic [7:0] a, input int n,
                             input logic [7:0] v, input string tag);
        logic [7:0] p;
        p = a;
        i2c_start();
        send(dev(half, 1'b0), 1'b1, tag);
        send(a, 1'b1, tag);
        for (int i = 0; i < n; i++) begin
            send(v + 8'(i), 1'b1, tag);
            mem_m[{half, p}] = v + 8'(i);
            p = nxt_wr(p);
        end
        i2c_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: released bus and erased array after reset
        check(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
        read_seq(1'b0, 8'h10, 2, "R1 erased readback");

        // R2: wrong type nibble and wrong strap are not acknowledged
        i2c_start(); send(8'hB4, 1'b0, "R2 bad type"); i2c_stop();
        i2c_start(); send({4'b1010, 2'b01, 2'b00}, 1'b0, "R2 bad strap"); i2c_stop();

        // R3/R5/R6: three-byte write, busy window polled inside and after
        write_seq(1'b0, 8'h05, 3, 8'h31, "R3 write");
        tick(20);
        i2c_start(); send(dev(1'b0, 1'b0), 1'b0, "R6 silent while busy"); i2c_stop();
        tick(200);
        i2c_start(); send(dev(1'b0, 1'b0), 1'b0, "R5 still busy"); i2c_stop();
        tick(300);
        i2c_start(); send(dev(1'b0, 1'b0), 1'b1, "R5 busy over"); i2c_stop();
        tick(20);
        read_seq(1'b0, 8'h05, 4, "R3 R10 readback");

        // R3: low three bits wrap inside the eight-byte group
        write_seq(1'b0, 8'h1E, 4, 8'h50, "R3 wrap write");
        tick(ERASE + 4*BYTEC + 50);
        read_seq(1'b0, 8'h18, 8, "R3 wrap readback");

        // R8/R2: full page into upper half, lower half at same pointer differs
        write_seq(1'b1, 8'h40, 8, 8'hA0, "R8 upper write");
        tick(ERASE + 8*BYTEC + 50);
        write_seq(1'b0, 8'h40, 1, 8'h07, "R2 lower write");
        tick(ERASE + BYTEC + 50);
        read_seq(1'b1, 8'h40, 8, "R8 upper readback");
        read_seq(1'b0, 8'h40, 1, "R2 half select");

        // R4: ninth byte refused, nothing written, no busy window
        i2c_start();
        send(dev(1'b0, 1'b0), 1'b1, "R4 dev");
        send(8'h60, 1'b1, "R4 word");
        for (int i = 0; i < 8; i++) send(8'h11 + 8'(i), 1'b1, "R4 accepted bytes");
        send(8'h99, 1'b0, "R4 ninth refused");
        i2c_stop();
        tick(20);
        i2c_start(); send(dev(1'b0, 1'b0), 1'b1, "R4 not busy"); i2c_stop();
        read_seq(1'b0, 8'h60, 8, "R4 unchanged");

        // R7: protect refuses upper-half data, lower half still writable
        wp = 1'b1;
        i2c_start();
        send(dev(1'b1, 1'b0), 1'b1, "R7 dev acked");
        send(8'h80, 1'b1, "R7 word acked");
        send(8'h5A, 1'b0, "R7 data refused");
        send(8'h5B, 1'b0, "R7 data refused");
        i2c_stop();
        tick(20);
        i2c_start(); send(dev(1'b1, 1'b0), 1'b1, "R7 no busy"); i2c_stop();
        write_seq(1'b0, 8'h88, 1, 8'h3C, "R7 lower writable");
        tick(ERASE + BYTEC + 50);
        read_seq(1'b1, 8'h80, 2, "R7 upper unchanged");
        read_seq(1'b0, 8'h88, 1, "R7 lower written");
        wp = 1'b0;

        // R9/R11: repeated start drops staged byte; stop without data starts no busy window
        i2c_start();
        send(dev(1'b0, 1'b0), 1'b1, "R9 dev");
        send(8'h30, 1'b1, "R9 word");
        send(8'hAA, 1'b1, "R9 staged");
        i2c_start();
        send(dev(1'b0, 1'b0), 1'b1, "R9 dev again");
        send(8'h50, 1'b1, "R9 word again");
        i2c_stop();
        tick(20);
        i2c_start(); send(dev(1'b0, 1'b0), 1'b1, "R11 not busy"); i2c_stop();
        read_seq(1'b0, 8'h30, 1, "R9 not committed");

        // R10: sequential read wraps over 8 bits inside the half
        write_seq(1'b0, 8'hFF, 1, 8'h6E, "R10 setup");
        tick(ERASE + BYTEC + 50);
        read_seq(1'b0, 8'hFE, 4, "R10 pointer wrap");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule